// File: doc/BRIEF.md
# Doorbell-Driven Queue Pair Engine

This block is the controller-side manager of one submission ring and one completion ring held in host memory. The host places commands in the submission ring and announces them by writing a new submission tail index. It reports consumed completions by writing a new completion head index. Both writes arrive through one doorbell write port. The engine walks every slot between its own submission head and the announced tail. For each slot it issues a fetch request for the 64-byte command, waits for a done notice from a processing stub, and then posts a completion entry into the completion ring. Each posted completion is followed by a one-cycle interrupt request.

Memory traffic is modelled as request/acknowledge handshakes: one for command fetches and one for completion writes. Ring sizes are programmed as the number of entries minus one, in a 16-bit field, so a ring may hold up to 65536 entries. A completion entry carries its ring index and a phase bit. It also carries the current submission head, which lets the host reclaim submission slots. The engine holds back completions while the completion ring is full.

Top module: `qp_engine`

## Requirements
- R1: After reset, fetchReq, cplReq, irqPulse and dbErr are 0, all four ring indices are 0 and the completion phase is 1.
- R2: While the submission head differs from the submission tail, the engine requests one fetch at a time, with fetchIdx equal to the submission head. fetchReq and fetchIdx hold steady until fetchAck. The head then advances and wraps to 0 after sqSizeM1.
- R3: After a fetched command is accepted, a cmdDone pulse leads to a completion request whose cplIdx equals the completion tail. The tail advances on cplAck and wraps to 0 after cqSizeM1.
- R4: cplPhase is 1 after reset and inverts each time the completion tail wraps from cqSizeM1 to 0.
- R5: cplSqHead reports the submission head after the slot of the completing command has been consumed.
- R6: The completion ring is full when (completion tail + 1, wrapped) equals the completion head. While it is full, cplReq stays 0. It is raised once a completion head doorbell frees a slot.
- R7: A doorbell write (dbSel 0 = submission tail, 1 = completion head) whose value exceeds the programmed size minus one is ignored and sets the sticky dbErr flag.
- R8: irqPulse is high for exactly the one cycle that follows each accepted completion handshake (cplReq and cplAck both high).
- R9: When the submission head equals the submission tail, no fetch is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sqSizeM1 | input | 16 | Submission ring entries minus one |
| cqSizeM1 | input | 16 | Completion ring entries minus one |
| dbWrEn | input | 1 | Doorbell write strobe |
| dbSel | input | 1 | 0: submission tail doorbell, 1: completion head doorbell |
| dbData | input | 16 | Doorbell value |
| fetchReq | output | 1 | Command fetch request |
| fetchIdx | output | 16 | Submission slot to fetch |
| fetchAck | input | 1 | Fetch accepted |
| cmdDone | input | 1 | Processing stub reports the command finished |
| cplReq | output | 1 | Completion write request |
| cplIdx | output | 16 | Completion slot to write |
| cplPhase | output | 1 | Phase bit of the entry |
| cplSqHead | output | 16 | Submission head reported in the entry |
| cplAck | input | 1 | Completion write accepted |
| irqPulse | output | 1 | One-cycle interrupt request |
| dbErr | output | 1 | Sticky invalid-doorbell flag |

## Verification
Some properties are checked on every cycle by the assertions. Both requests hold with stable indices until acknowledged. No completion is requested into a full ring. Every interrupt lasts one cycle and follows a completion handshake. The error flag never clears, and the fetch index never exceeds the programmed size. The order of fetched slots and of completion slots, wrap-around, phase inversion, the reported submission head, and the effect of ignored doorbells can only be shown by the bench's scenarios. Those scenarios include a doorbell sequence that wraps both rings, a stall on a full completion ring, and out-of-range doorbell values.

// File: rtl/qp_pkg.sv
package qp_pkg;
  typedef struct packed {
    logic advSqHead;
    logic advCqTail;
  } qpStrobes_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_WORK  = 2'd2,
    S_POST  = 2'd3
  } qpState_t;
endpackage

// File: rtl/qp_datapath.sv
module qp_datapath
  import qp_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PTR_W-1:0] sqSizeM1,
  input  logic [PTR_W-1:0] cqSizeM1,
  input  logic             dbWrEn,
  input  logic             dbSel,
  input  logic [PTR_W-1:0] dbData,
  input  qpStrobes_t       strobes,
  output logic [PTR_W-1:0] sqHead,
  output logic [PTR_W-1:0] cqHead,
  output logic [PTR_W-1:0] cqTail,
  output logic             phase,
  output logic             sqEmpty,
  output logic             cqFull,
  output logic             dbErr
);
  logic [PTR_W-1:0] sqTail;
  logic [PTR_W-1:0] cqTailNext;
  logic             sqDbOk;
  logic             cqDbOk;

  function automatic logic [PTR_W-1:0] wrapInc(input logic [PTR_W-1:0] idx,
                                               input logic [PTR_W-1:0] lastIdx);
    return (idx == lastIdx) ? '0 : idx + 1'b1;
  endfunction

  assign cqTailNext = wrapInc(cqTail, cqSizeM1);
  assign sqEmpty    = (sqHead == sqTail);
  assign cqFull     = (cqTailNext == cqHead);
  assign sqDbOk     = (dbData <= sqSizeM1);
  assign cqDbOk     = (dbData <= cqSizeM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sqHead <= '0;
      sqTail <= '0;
      cqHead <= '0;
      cqTail <= '0;
      phase  <= 1'b1;
      dbErr  <= 1'b0;
    end else begin
      if (dbWrEn) begin
        if (!dbSel) begin
          if (sqDbOk) sqTail <= dbData;
          else        dbErr  <= 1'b1;
        end else begin
          if (cqDbOk) cqHead <= dbData;
          else        dbErr  <= 1'b1;
        end
      end
      if (strobes.advSqHead) sqHead <= wrapInc(sqHead, sqSizeM1);
      if (strobes.advCqTail) begin
        cqTail <= cqTailNext;
        if (cqTail == cqSizeM1) phase <= ~phase;
      end
    end
  end
endmodule

// File: rtl/qp_control.sv
module qp_control
  import qp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sqEmpty,
  input  logic       cqFull,
  input  logic       fetchAck,
  input  logic       cmdDone,
  input  logic       cplAck,
  output logic       fetchReq,
  output logic       cplReq,
  output logic       irqPulse,
  output qpStrobes_t strobes
);
  qpState_t state;
  qpState_t stateNext;

  assign fetchReq = (state == S_FETCH);
  assign cplReq   = (state == S_POST) && !cqFull;

  always_comb begin
    stateNext         = state;
    strobes.advSqHead = 1'b0;
    strobes.advCqTail = 1'b0;
    case (state)
      S_IDLE:  if (!sqEmpty) stateNext = S_FETCH;
      S_FETCH: if (fetchAck) begin
                 strobes.advSqHead = 1'b1;
                 stateNext         = S_WORK;
               end
      S_WORK:  if (cmdDone) stateNext = S_POST;
      S_POST:  if (cplReq && cplAck) begin
                 strobes.advCqTail = 1'b1;
                 stateNext         = S_IDLE;
               end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      irqPulse <= 1'b0;
    end else begin
      state    <= stateNext;
      irqPulse <= cplReq && cplAck;
    end
  end
endmodule

// File: rtl/qp_engine.sv
module qp_engine
  import qp_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PTR_W-1:0] sqSizeM1,
  input  logic [PTR_W-1:0] cqSizeM1,
  input  logic             dbWrEn,
  input  logic             dbSel,
  input  logic [PTR_W-1:0] dbData,
  output logic             fetchReq,
  output logic [PTR_W-1:0] fetchIdx,
  input  logic             fetchAck,
  input  logic             cmdDone,
  output logic             cplReq,
  output logic [PTR_W-1:0] cplIdx,
  output logic             cplPhase,
  output logic [PTR_W-1:0] cplSqHead,
  input  logic             cplAck,
  output logic             irqPulse,
  output logic             dbErr
);
  qpStrobes_t       strobes;
  logic [PTR_W-1:0] sqHeadW;
  logic [PTR_W-1:0] cqHeadW;
  logic [PTR_W-1:0] cqTailW;
  logic             phaseW;
  logic             sqEmptyW;
  logic             cqFullW;

  qp_datapath #(.PTR_W(PTR_W)) dp_i (
    .clk(clk), .rstN(rstN), .sqSizeM1(sqSizeM1), .cqSizeM1(cqSizeM1),
    .dbWrEn(dbWrEn), .dbSel(dbSel), .dbData(dbData), .strobes(strobes),
    .sqHead(sqHeadW), .cqHead(cqHeadW), .cqTail(cqTailW), .phase(phaseW),
    .sqEmpty(sqEmptyW), .cqFull(cqFullW), .dbErr(dbErr)
  );

  qp_control ctl_i (
    .clk(clk), .rstN(rstN), .sqEmpty(sqEmptyW), .cqFull(cqFullW),
    .fetchAck(fetchAck), .cmdDone(cmdDone), .cplAck(cplAck),
    .fetchReq(fetchReq), .cplReq(cplReq), .irqPulse(irqPulse),
    .strobes(strobes)
  );

  assign fetchIdx  = sqHeadW;
  assign cplIdx    = cqTailW;
  assign cplPhase  = phaseW;
  assign cplSqHead = sqHeadW;
endmodule

// File: rtl/qp_engine_chk.sv
module qp_engine_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [PTR_W-1:0] sqSizeM1,
  input logic [PTR_W-1:0] cqSizeM1,
  input logic             fetchReq,
  input logic [PTR_W-1:0] fetchIdx,
  input logic             fetchAck,
  input logic             cplReq,
  input logic [PTR_W-1:0] cplIdx,
  input logic             cplAck,
  input logic [PTR_W-1:0] cqHead,
  input logic             irqPulse,
  input logic             dbErr
);
  logic [PTR_W-1:0] cplSlotAfter;
  assign cplSlotAfter = (cplIdx == cqSizeM1) ? '0 : cplIdx + 1'b1;

  // R2: fetch request held with a stable index until acknowledged
  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchAck |=> fetchReq && $stable(fetchIdx));

  // R2: fetch index inside the programmed submission ring
  p_fetch_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> fetchIdx <= sqSizeM1);

  // R3: completion request held with a stable index until acknowledged
  p_cpl_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    cplReq && !cplAck |=> cplReq && $stable(cplIdx));

  // R6: never request a completion into a full ring
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    cplReq |-> cplSlotAfter != cqHead);

  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    dbErr |=> dbErr);

  // R8: interrupt lasts one cycle
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R8: interrupt only follows a completion handshake
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPulse) |-> $past(cplReq && cplAck));
endmodule

bind qp_engine qp_engine_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rstN(rstN), .sqSizeM1(sqSizeM1), .cqSizeM1(cqSizeM1),
  .fetchReq(fetchReq), .fetchIdx(fetchIdx), .fetchAck(fetchAck),
  .cplReq(cplReq), .cplIdx(cplIdx), .cplAck(cplAck), .cqHead(cqHeadW),
  .irqPulse(irqPulse), .dbErr(dbErr)
);

// File: tb/qp_engine_tb.sv
module qp_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W      = 16;
  localparam int SQ_LAST    = 3;
  localparam int CQ_LAST    = 2;
  localparam int NVEC       = 5;
  localparam int VEC_TAIL [NVEC] = '{2, 3, 0, 1, 3};
  localparam int VEC_CNT  [NVEC] = '{2, 1, 1, 1, 2};

  logic             clk = 1'b0;
  logic             rstN;
  logic [PTR_W-1:0] sqSizeM1, cqSizeM1, dbData, fetchIdx, cplIdx, cplSqHead;
  logic             dbWrEn, dbSel, fetchReq, fetchAck, cmdDone;
  logic             cplReq, cplPhase, cplAck, irqPulse, dbErr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int expSqHead = 0;
  int expCqTail = 0;
  bit expPhase  = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  qp_engine #(.PTR_W(PTR_W)) dut_i (
    .clk(clk), .rstN(rstN), .sqSizeM1(sqSizeM1), .cqSizeM1(cqSizeM1),
    .dbWrEn(dbWrEn), .dbSel(dbSel), .dbData(dbData),
    .fetchReq(fetchReq), .fetchIdx(fetchIdx), .fetchAck(fetchAck),
    .cmdDone(cmdDone), .cplReq(cplReq), .cplIdx(cplIdx), .cplPhase(cplPhase),
    .cplSqHead(cplSqHead), .cplAck(cplAck), .irqPulse(irqPulse), .dbErr(dbErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ringDb(input logic sel, input int v);
    dbWrEn = 1'b1; dbSel = sel; dbData = PTR_W'(v);
    @(negedge clk);
    dbWrEn = 1'b0;
  endtask

  task automatic fetchAndRun();
    for (int n = 0; n < 50 && !fetchReq; n++) @(negedge clk);
    check(fetchReq, "R2 fetch requested", int'(fetchReq), 1);
    check(fetchIdx == PTR_W'(expSqHead), "R2 fetch index", int'(fetchIdx), expSqHead);
    fetchAck = 1'b1;
    @(negedge clk);
    fetchAck = 1'b0;
    expSqHead = (expSqHead == SQ_LAST) ? 0 : expSqHead + 1;
    cmdDone = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
  endtask

  task automatic postOne(input bit consume);
    for (int n = 0; n < 50 && !cplReq; n++) @(negedge clk);
    check(cplReq, "R3 completion requested", int'(cplReq), 1);
    check(cplIdx == PTR_W'(expCqTail), "R3 completion index", int'(cplIdx), expCqTail);
    check(cplPhase == expPhase, "R4 phase bit", int'(cplPhase), int'(expPhase));
    check(cplSqHead == PTR_W'(expSqHead), "R5 reported sq head", int'(cplSqHead), expSqHead);
    cplAck = 1'b1;
    @(negedge clk);
    cplAck = 1'b0;
    check(irqPulse, "R8 irq after completion", int'(irqPulse), 1);
    if (expCqTail == CQ_LAST) begin
      expCqTail = 0;
      expPhase  = ~expPhase;
    end else expCqTail++;
    @(negedge clk);
    check(!irqPulse, "R8 irq single cycle", int'(irqPulse), 0);
    if (consume) ringDb(1'b1, expCqTail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sqSizeM1 = PTR_W'(SQ_LAST); cqSizeM1 = PTR_W'(CQ_LAST);
    dbWrEn = 1'b0; dbSel = 1'b0; dbData = '0;
    fetchAck = 1'b0; cmdDone = 1'b0; cplAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!fetchReq, "R1 fetchReq after reset", int'(fetchReq), 0);
    check(!cplReq, "R1 cplReq after reset", int'(cplReq), 0);
    check(!irqPulse, "R1 irq after reset", int'(irqPulse), 0);
    check(!dbErr, "R1 dbErr after reset", int'(dbErr), 0);

    // Vector walk: R2 R3 R4 R5 with both rings wrapping
    for (int v = 0; v < NVEC; v++) begin
      ringDb(1'b0, VEC_TAIL[v]);
      for (int c = 0; c < VEC_CNT[v]; c++) begin
        fetchAndRun();
        postOne(1'b1);
      end
      repeat (3) @(negedge clk);
      check(!fetchReq, "R9 no fetch once ring drained", int'(fetchReq), 0);
    end
    check(!dbErr, "R7 no error on valid doorbells", int'(dbErr), 0);

    // R7: out-of-range submission tail ignored
    ringDb(1'b0, SQ_LAST + 1);
    check(dbErr, "R7 error set on bad sq doorbell", int'(dbErr), 1);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      check(!fetchReq, "R7 bad sq doorbell ignored", int'(fetchReq), 0);
    end

    // R6: full completion ring stalls posting
    ringDb(1'b0, (expSqHead + 3) % (SQ_LAST + 1));
    fetchAndRun();
    postOne(1'b0);
    fetchAndRun();
    postOne(1'b0);
    fetchAndRun();
    for (int n = 0; n < 6; n++) begin
      check(!cplReq, "R6 stall on full ring", int'(cplReq), 0);
      @(negedge clk);
    end
    ringDb(1'b1, CQ_LAST + 1);
    check(!cplReq, "R7 bad cq doorbell ignored", int'(cplReq), 0);
    check(dbErr, "R7 error stays set", int'(dbErr), 1);
    ringDb(1'b1, expCqTail);
    check(cplReq, "R6 resume after head doorbell", int'(cplReq), 1);
    postOne(1'b1);
    repeat (3) @(negedge clk);
    check(!fetchReq, "R9 idle at end", int'(fetchReq), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule